// File: doc/BRIEF.md
# Dual-Lane Multiply-Accumulate Datapath

This block is the arithmetic core of a fixed-point audio signal processor. Each accepted instruction carries two lane operations. Every lane takes one signed 32-bit operand from a bank of X operand registers and one from a bank of Y operand registers. It then clears, loads, adds its product to, or subtracts its product from one accumulator in a shared bank. The bank holds wide accumulators with guard bits. Two such operations finish on every clock cycle. The product is registered in the first stage and the accumulator is updated in the second.

The instruction input is a valid/ready stream. Its ready is high at all times outside reset, so the block never back-pressures its issuer. Accumulator readout is a request/response pair of valid/ready streams. A request is taken when `rq_valid` and `rq_ready` are both high. The response register holds one result, and while it is full and `rd_ready` is low, `rq_ready` stays low and the result and its valid remain unchanged. The result is the selected accumulator's Q31 field, rounded to nearest and saturated to the signed 32-bit range.

Top module: `dual_mac_core`

## Requirements
- R1: Synchronous active-high reset clears all accumulators and all X and Y operand registers to zero, and holds `rd_valid` and `conflict` low.
- R2: An operand register write (`xw_en`/`yw_en`) takes effect at the clock edge. An instruction accepted at that same edge reads the previous contents.
- R3: Opcode 3 (MAC) adds the full signed product X*Y to the target accumulator, and opcode 4 (MSU) subtracts it. Both lanes operate independently in the same cycle.
- R4: Opcode 2 (LOAD) sets the accumulator to the X operand scaled by 2^31, so that it reads back as that X value. Opcode 1 (CLR) sets it to zero. Opcode 0 (NOP) changes nothing.
- R5: An instruction accepted at edge k updates its accumulator at edge k+1. A read request accepted at edge k+1 returns the old value, and one accepted at k+2 or later returns the new value. Back-to-back operations on one accumulator lose no update.
- R6: When both lanes carry a non-NOP opcode to the same accumulator, only lane 0 is applied. `conflict` is high for exactly the one cycle after the edge that applies it. There is no conflict if either lane is NOP.
- R7: Readout returns accumulator bits [62:31] after adding 2^30, which rounds to nearest with halves rounding upward.
- R8: If the rounded value lies outside the signed 32-bit range, the readout returns 0x7FFFFFFF for positive accumulators and 0x80000000 for negative ones.
- R9: `rq_ready` equals `!rd_valid || rd_ready`. An accepted request makes `rd_valid` high after the next edge. While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold.
- R10: `in_ready` is low during reset and high otherwise. Lane fields presented with `in_valid` low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction valid |
| in_ready | output | 1 | Instruction ready |
| ln0_op | input | 3 | Lane 0 opcode (0 NOP, 1 CLR, 2 LOAD, 3 MAC, 4 MSU) |
| ln0_acc | input | AW (3) | Lane 0 target accumulator |
| ln0_xsel | input | IW (2) | Lane 0 X register select |
| ln0_ysel | input | IW (2) | Lane 0 Y register select |
| ln1_op | input | 3 | Lane 1 opcode |
| ln1_acc | input | AW (3) | Lane 1 target accumulator |
| ln1_xsel | input | IW (2) | Lane 1 X register select |
| ln1_ysel | input | IW (2) | Lane 1 Y register select |
| xw_en | input | 1 | X register write enable |
| xw_idx | input | IW (2) | X register write index |
| xw_data | input | DW (32) | X register write data |
| yw_en | input | 1 | Y register write enable |
| yw_idx | input | IW (2) | Y register write index |
| yw_data | input | DW (32) | Y register write data |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request ready |
| rq_sel | input | AW (3) | Accumulator to read |
| rd_valid | output | 1 | Read result valid |
| rd_ready | input | 1 | Read result ready |
| rd_data | output | DW (32) | Rounded, saturated result |
| conflict | output | 1 | Same-accumulator lane collision, one cycle |

## Verification
The bench builds the block with its defaults: 32-bit data, four X and four Y registers, eight accumulators and eight guard bits. With these values, full-scale products of 0x7FFFFFFF and 0x80000000 push an accumulator past the Q31 range, so both saturation directions can be reached within the guard bits. Small products of 1 and 2^30 hit the exact half-LSB rounding boundary. The 3-bit accumulator select lets lane collisions and back-to-back chains be placed on separate accumulators that the bench reads back one by one.

// File: rtl/mac2_pkg.sv
package mac2_pkg;
  localparam int NLANE = 2;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_CLR  = 3'd1,
    OP_LOAD = 3'd2,
    OP_MAC  = 3'd3,
    OP_MSU  = 3'd4
  } mac_op_e;
endpackage

// File: rtl/mac2_oprf.sv
module mac2_oprf #(
  parameter int DW   = 32,
  parameter int NREG = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ra0,
  input  logic [IW-1:0] ra1,
  output logic [DW-1:0] rd0,
  output logic [DW-1:0] rd1
);
  logic [DW-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) mem[i] <= '0;
      else if (we && widx == IW'(i)) mem[i] <= wdata;
    end
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];

  AST_OPRF_WRITE: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(widx)] == $past(wdata)); // R2
endmodule

// File: rtl/mac2_lane.sv
module mac2_lane
  import mac2_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NACC = 8,
  localparam int AW  = $clog2(NACC),
  localparam int TW  = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic [2:0]           op,
  input  logic [AW-1:0]        asel,
  input  logic [DW-1:0]        xv,
  input  logic [DW-1:0]        yv,
  output logic                 s_vld,
  output logic [2:0]           s_op,
  output logic [AW-1:0]        s_asel,
  output logic signed [TW-1:0] s_term
);
  logic signed [TW-1:0] prod;
  logic signed [TW-1:0] term_d;

  assign prod = $signed(xv) * $signed(yv);

  always_comb begin
    case (mac_op_e'(op))
      OP_MAC, OP_MSU: term_d = prod;
      OP_LOAD:        term_d = {xv[DW-1], xv, {(DW-1){1'b0}}};
      default:        term_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_vld  <= 1'b0;
      s_op   <= 3'd0;
      s_asel <= '0;
      s_term <= '0;
    end else begin
      s_vld  <= fire && (mac_op_e'(op) != OP_NOP);
      s_op   <= op;
      s_asel <= asel;
      s_term <= term_d;
    end
  end

  AST_LANE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !s_vld); // R10
endmodule

// File: rtl/mac2_acc_bank.sv
module mac2_acc_bank
  import mac2_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NACC  = 8,
  parameter int GUARD = 8,
  localparam int AW   = $clog2(NACC),
  localparam int TW   = 2 * DW,
  localparam int ACCW = TW + GUARD,
  localparam int RW   = ACCW - DW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v0,
  input  logic [2:0]           o0,
  input  logic [AW-1:0]        a0,
  input  logic signed [TW-1:0] t0,
  input  logic                 v1,
  input  logic [2:0]           o1,
  input  logic [AW-1:0]        a1,
  input  logic signed [TW-1:0] t1,
  input  logic [AW-1:0]        rsel,
  output logic [RW-1:0]        rtop,
  output logic                 conflict_q
);
  logic [ACCW-1:0]      acc_q [NACC];
  logic [NACC*ACCW-1:0] acc_flat;

  function automatic logic [ACCW-1:0] upd(input logic [ACCW-1:0] cur,
                                          input logic [2:0] op,
                                          input logic [TW-1:0] term);
    logic [ACCW-1:0] ext;
    ext = {{GUARD{term[TW-1]}}, term};
    case (mac_op_e'(op))
      OP_CLR:  upd = '0;
      OP_LOAD: upd = ext;
      OP_MAC:  upd = cur + ext;
      OP_MSU:  upd = cur - ext;
      default: upd = cur;
    endcase
  endfunction

  for (genvar i = 0; i < NACC; i++) begin : g_acc
    logic            hit0, hit1;
    logic [ACCW-1:0] nxt;
    assign hit0 = v0 && (a0 == AW'(i));
    assign hit1 = v1 && (a1 == AW'(i)) && !hit0;
    always_comb begin
      if (hit0)      nxt = upd(acc_q[i], o0, t0);
      else if (hit1) nxt = upd(acc_q[i], o1, t1);
      else           nxt = acc_q[i];
    end
    always_ff @(posedge clk) begin
      if (rst) acc_q[i] <= '0;
      else     acc_q[i] <= nxt;
    end
    assign acc_flat[i*ACCW +: ACCW] = acc_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) conflict_q <= 1'b0;
    else     conflict_q <= v0 && v1 && (a0 == a1);
  end

  assign rtop = acc_q[rsel][ACCW-1:DW-2];

  AST_LANE0_WINS: assert property (@(posedge clk) disable iff (rst)
    (v0 && v1 && a0 == a1 && mac_op_e'(o0) == OP_CLR) |=> acc_q[$past(a0)] == '0); // R6

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (v0 && mac_op_e'(o0) == OP_CLR) |=> acc_q[$past(a0)] == '0); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!v0 && !v1) |=> $stable(acc_flat)); // R10
endmodule

// File: rtl/mac2_rdout.sv
module mac2_rdout #(
  parameter int DW    = 32,
  parameter int ACCW  = 72,
  localparam int RW   = ACCW - DW + 2,
  localparam int W2   = RW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rq_valid,
  output logic          rq_ready,
  input  logic [RW-1:0] acc_top,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data
);
  logic [W2-1:0] base;
  logic [W2-1:0] rnd;
  logic [W2-DW:0] hi;
  logic          ovf;
  logic [DW-1:0] res;
  logic          fire;

  // acc_top[0] is the half-LSB bit; adding it rounds to nearest
  assign base = {acc_top[RW-1], acc_top[RW-1], acc_top[RW-1:1]};
  assign rnd  = base + W2'(acc_top[0]);
  assign hi   = rnd[W2-1:DW-1];
  assign ovf  = !((&hi) || !(|hi));

  always_comb begin
    if (ovf) res = acc_top[RW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    else     res = rnd[DW-1:0];
  end

  assign rq_ready = !rd_valid || rd_ready;
  assign fire     = rq_valid && rq_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (fire) begin
        rd_valid <= 1'b1;
        rd_data  <= res;
      end else if (rd_ready) begin
        rd_valid <= 1'b0;
      end
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R9

  AST_RD_FILL: assert property (@(posedge clk) disable iff (rst)
    fire |=> rd_valid); // R9

  AST_SAT_SIGN: assert property (@(posedge clk) disable iff (rst)
    (fire && !acc_top[RW-1]) |=> !rd_data[DW-1]); // R8
endmodule

// File: rtl/dual_mac_core.sv
module dual_mac_core
  import mac2_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREG  = 4,
  parameter int NACC  = 8,
  parameter int GUARD = 8,
  localparam int IW   = $clog2(NREG),
  localparam int AW   = $clog2(NACC),
  localparam int TW   = 2 * DW,
  localparam int ACCW = TW + GUARD,
  localparam int RW   = ACCW - DW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    ln0_op,
  input  logic [AW-1:0] ln0_acc,
  input  logic [IW-1:0] ln0_xsel,
  input  logic [IW-1:0] ln0_ysel,
  input  logic [2:0]    ln1_op,
  input  logic [AW-1:0] ln1_acc,
  input  logic [IW-1:0] ln1_xsel,
  input  logic [IW-1:0] ln1_ysel,
  input  logic          xw_en,
  input  logic [IW-1:0] xw_idx,
  input  logic [DW-1:0] xw_data,
  input  logic          yw_en,
  input  logic [IW-1:0] yw_idx,
  input  logic [DW-1:0] yw_data,
  input  logic          rq_valid,
  output logic          rq_ready,
  input  logic [AW-1:0] rq_sel,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          conflict
);
  logic                 fire;
  logic [2:0]           l_op   [NLANE];
  logic [AW-1:0]        l_acc  [NLANE];
  logic [IW-1:0]        l_xs   [NLANE];
  logic [IW-1:0]        l_ys   [NLANE];
  logic [DW-1:0]        l_x    [NLANE];
  logic [DW-1:0]        l_y    [NLANE];
  logic                 s_vld  [NLANE];
  logic [2:0]           s_op   [NLANE];
  logic [AW-1:0]        s_asel [NLANE];
  logic signed [TW-1:0] s_term [NLANE];
  logic [RW-1:0]        sel_top;

  assign in_ready = !rst;
  assign fire     = in_valid && in_ready;

  assign l_op[0]  = ln0_op;
  assign l_acc[0] = ln0_acc;
  assign l_xs[0]  = ln0_xsel;
  assign l_ys[0]  = ln0_ysel;
  assign l_op[1]  = ln1_op;
  assign l_acc[1] = ln1_acc;
  assign l_xs[1]  = ln1_xsel;
  assign l_ys[1]  = ln1_ysel;

  mac2_oprf #(.DW(DW), .NREG(NREG)) u_xrf (
    .clk(clk), .rst(rst), .we(xw_en), .widx(xw_idx), .wdata(xw_data),
    .ra0(l_xs[0]), .ra1(l_xs[1]), .rd0(l_x[0]), .rd1(l_x[1])
  );

  mac2_oprf #(.DW(DW), .NREG(NREG)) u_yrf (
    .clk(clk), .rst(rst), .we(yw_en), .widx(yw_idx), .wdata(yw_data),
    .ra0(l_ys[0]), .ra1(l_ys[1]), .rd0(l_y[0]), .rd1(l_y[1])
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    mac2_lane #(.DW(DW), .NACC(NACC)) u_lane (
      .clk(clk), .rst(rst), .fire(fire), .op(l_op[g]), .asel(l_acc[g]),
      .xv(l_x[g]), .yv(l_y[g]), .s_vld(s_vld[g]), .s_op(s_op[g]),
      .s_asel(s_asel[g]), .s_term(s_term[g])
    );
  end

  mac2_acc_bank #(.DW(DW), .NACC(NACC), .GUARD(GUARD)) u_bank (
    .clk(clk), .rst(rst),
    .v0(s_vld[0]), .o0(s_op[0]), .a0(s_asel[0]), .t0(s_term[0]),
    .v1(s_vld[1]), .o1(s_op[1]), .a1(s_asel[1]), .t1(s_term[1]),
    .rsel(rq_sel), .rtop(sel_top), .conflict_q(conflict)
  );

  mac2_rdout #(.DW(DW), .ACCW(ACCW)) u_rd (
    .clk(clk), .rst(rst), .rq_valid(rq_valid), .rq_ready(rq_ready),
    .acc_top(sel_top), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  AST_CONFLICT_PULSE: assert property (@(posedge clk) disable iff (rst)
    (!fire) |=> ##1 !conflict); // R6
endmodule

// File: tb/test_dual_mac_core.sv
module test_dual_mac_core;
  localparam int CLK_P = 10;
  localparam logic [2:0] NOP = 3'd0, CLR = 3'd1, LOAD = 3'd2, MAC = 3'd3, MSU = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [2:0] ln0_op = '0, ln1_op = '0;
  logic [2:0] ln0_acc = '0, ln1_acc = '0;
  logic [1:0] ln0_xsel = '0, ln0_ysel = '0, ln1_xsel = '0, ln1_ysel = '0;
  logic xw_en = 1'b0, yw_en = 1'b0;
  logic [1:0] xw_idx = '0, yw_idx = '0;
  logic [31:0] xw_data = '0, yw_data = '0;
  logic rq_valid = 1'b0, rq_ready;
  logic [2:0] rq_sel = '0;
  logic rd_valid, rd_ready = 1'b1;
  logic [31:0] rd_data;
  logic conflict;

  int n_chk = 0, n_bad = 0;
  logic signed [71:0] macc [8];
  logic [31:0] mx [4], my [4];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_P/2) clk = ~clk;

  dual_mac_core i_dual_mac_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .ln0_op(ln0_op), .ln0_acc(ln0_acc), .ln0_xsel(ln0_xsel), .ln0_ysel(ln0_ysel),
    .ln1_op(ln1_op), .ln1_acc(ln1_acc), .ln1_xsel(ln1_xsel), .ln1_ysel(ln1_ysel),
    .xw_en(xw_en), .xw_idx(xw_idx), .xw_data(xw_data),
    .yw_en(yw_en), .yw_idx(yw_idx), .yw_data(yw_data),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_sel(rq_sel),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .conflict(conflict)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] expect_rd(input logic signed [71:0] a);
    logic signed [72:0] s;
    logic signed [72:0] q;
    s = 73'(a) + 73'sd1073741824;
    q = s >>> 31;
    if (q > 73'sd2147483647) return 32'h7FFFFFFF;
    if (q < -73'sd2147483648) return 32'h80000000;
    return q[31:0];
  endfunction

  function automatic logic signed [71:0] model_op(input logic [2:0] op,
      input logic signed [71:0] cur, input logic [31:0] x, input logic [31:0] y);
    logic signed [71:0] xs, ys;
    xs = 72'($signed(x));
    ys = 72'($signed(y));
    case (op)
      CLR:     return '0;
      LOAD:    return xs * 72'sd2147483648;
      MAC:     return cur + xs * ys;
      MSU:     return cur - xs * ys;
      default: return cur;
    endcase
  endfunction

  // scoreboard monitor: handshake completes at the next edge
  always @(negedge clk) begin
    if (!rst && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R9: unexpected result %h expected none", rd_data);
      end else begin
        chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic wr_regs(input int xi, input logic [31:0] xd, input int yi, input logic [31:0] yd);
    xw_en = 1'b1; xw_idx = 2'(xi); xw_data = xd;
    yw_en = 1'b1; yw_idx = 2'(yi); yw_data = yd;
    step();
    xw_en = 1'b0; yw_en = 1'b0;
    mx[xi] = xd; my[yi] = yd;
  endtask

  task automatic issue(input logic [2:0] o0, input int a0, input int x0, input int y0,
                       input logic [2:0] o1, input int a1, input int x1, input int y1);
    logic signed [71:0] r0, r1;
    ln0_op = o0; ln0_acc = 3'(a0); ln0_xsel = 2'(x0); ln0_ysel = 2'(y0);
    ln1_op = o1; ln1_acc = 3'(a1); ln1_xsel = 2'(x1); ln1_ysel = 2'(y1);
    in_valid = 1'b1;
    r0 = model_op(o0, macc[a0], mx[x0], my[y0]);
    r1 = model_op(o1, macc[a1], mx[x1], my[y1]);
    step();
    in_valid = 1'b0;
    if (o0 != NOP) macc[a0] = r0;
    if (o1 != NOP && !(o0 != NOP && a0 == a1)) macc[a1] = r1;
  endtask

  task automatic rd_req(input int sel, input logic [31:0] expv, input string tag);
    rq_valid = 1'b1; rq_sel = 3'(sel);
    while (!rq_ready) step();
    exp_q.push_back(expv); tag_q.push_back(tag);
    step();
    rq_valid = 1'b0;
  endtask

  task automatic read_acc(input int sel, input string tag);
    step(); step();
    rd_req(sel, expect_rd(macc[sel]), tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    for (int i = 0; i < 8; i++) macc[i] = '0;
    for (int i = 0; i < 4; i++) begin mx[i] = '0; my[i] = '0; end
    step(); step();
    chk("R10 in_ready during reset", {31'd0, in_ready}, 32'd0);
    rst = 1'b0;
    step();
    chk("R1 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
    chk("R1 conflict after reset", {31'd0, conflict}, 32'd0);
    chk("R10 in_ready after reset", {31'd0, in_ready}, 32'd1);
    read_acc(5, "R1 acc5 cleared");
    issue(LOAD, 0, 3, 0, NOP, 1, 0, 0);
    read_acc(0, "R1 X3 cleared");

    wr_regs(0, 32'h40000000, 0, 32'h40000000);
    wr_regs(1, 32'h20000000, 1, 32'hC0000000);
    wr_regs(2, 32'h7FFFFFFF, 2, 32'h7FFFFFFF);
    wr_regs(3, 32'h80000000, 3, 32'h00000001);

    // R3 two lanes at once
    issue(MAC, 1, 0, 0, MAC, 2, 1, 1);
    read_acc(1, "R3 lane0 MAC");
    read_acc(2, "R3 lane1 MAC negative");
    issue(MSU, 1, 0, 1, NOP, 0, 0, 0);
    read_acc(1, "R3 MSU");

    // R4 load, clear, nop
    issue(LOAD, 3, 1, 0, NOP, 1, 2, 2);
    read_acc(3, "R4 LOAD");
    read_acc(1, "R4 NOP keeps acc1");
    issue(CLR, 2, 0, 0, NOP, 2, 0, 0);
    read_acc(2, "R4 CLR");

    // R5 back-to-back chain
    for (int k = 0; k < 4; k++) issue(MAC, 4, 1, 0, NOP, 0, 0, 0);
    read_acc(4, "R5 back-to-back");
    chk("R5 chain model", expect_rd(macc[4]), 32'h40000000);
    // R5 read timing boundary
    issue(LOAD, 5, 0, 0, NOP, 0, 0, 0);
    rd_req(5, 32'h00000000, "R5 read at k+1 sees old");
    rd_req(5, 32'h40000000, "R5 read at k+2 sees new");

    // R6 conflict
    issue(LOAD, 6, 1, 0, LOAD, 6, 0, 0);
    chk("R6 conflict before", {31'd0, conflict}, 32'd0);
    step();
    chk("R6 conflict pulse", {31'd0, conflict}, 32'd1);
    step();
    chk("R6 conflict drops", {31'd0, conflict}, 32'd0);
    read_acc(6, "R6 lane0 wins");
    issue(NOP, 7, 0, 0, LOAD, 7, 2, 0);
    step();
    chk("R6 no conflict with NOP", {31'd0, conflict}, 32'd0);
    read_acc(7, "R6 lane1 alone");

    // R7 rounding
    wr_regs(1, 32'h3FFFFFFF, 3, 32'h00000001);
    issue(CLR, 0, 0, 0, CLR, 1, 0, 0);
    issue(MAC, 0, 0, 3, MAC, 1, 1, 3);
    read_acc(0, "R7 half rounds up");
    chk("R7 half model", expect_rd(macc[0]), 32'h00000001);
    read_acc(1, "R7 below half");
    issue(CLR, 2, 0, 0, NOP, 0, 0, 0);
    issue(MSU, 2, 0, 3, NOP, 0, 0, 0);
    read_acc(2, "R7 negative half");

    // R8 saturation
    issue(LOAD, 3, 2, 0, LOAD, 4, 3, 0);
    issue(MAC, 3, 2, 2, MSU, 4, 2, 2);
    read_acc(3, "R8 positive saturation");
    read_acc(4, "R8 negative saturation");
    chk("R8 neg model", expect_rd(macc[4]), 32'h80000000);

    // R2 same-edge write reads old value
    xw_en = 1'b1; xw_idx = 2'd0; xw_data = 32'h10000000;
    issue(LOAD, 5, 0, 0, NOP, 0, 0, 0);
    xw_en = 1'b0; mx[0] = 32'h10000000;
    read_acc(5, "R2 same-edge old operand");
    issue(LOAD, 5, 0, 0, NOP, 0, 0, 0);
    read_acc(5, "R2 new operand");

    // R9 back-pressure
    step(); step();
    rd_ready = 1'b0;
    rd_req(6, expect_rd(macc[6]), "R9 held result");
    held = rd_data;
    chk("R9 rq_ready low when full", {31'd0, rq_ready}, 32'd0);
    step(); step(); step();
    chk("R9 valid held", {31'd0, rd_valid}, 32'd1);
    chk("R9 data stable", rd_data, held);
    rd_ready = 1'b1;
    step();

    // R10 in_valid low ignored
    ln0_op = LOAD; ln0_acc = 3'd6; ln0_xsel = 2'd2;
    ln1_op = CLR; ln1_acc = 3'd3;
    step(); step(); step();
    ln0_op = NOP; ln1_op = NOP;
    read_acc(6, "R10 acc6 untouched");
    read_acc(3, "R10 acc3 untouched");

    step(); step(); step();
    chk("R9 all results drained", 32'(exp_q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule